// File: doc/BRIEF.md
# USB Host Pipe Transaction Scheduler

This block decides, frame by frame, which pipe of a USB host controller is served next and what kind of transaction it gets. Every frame begins with a start-of-frame. The block then runs three phases in a fixed sequence. The first is a periodic pass over the interrupt and isochronous pipes. The second is a single check of the default control pipe for a pending setup request. The third is a bulk and control pass that keeps repeating while the frame still has time left.

Each pipe reports its state on parallel inputs: its transfer type, its direction, whether its PID is set to BUF, whether it has free receive space, whether it has data waiting to send, and whether its interval counter falls due in this frame. The block raises one transaction request at a time, naming the pipe and the kind of transaction. It holds that request until the packet engine reports completion, and the response the device gave does not matter.

An enable input gates the whole block. Raising the enable starts start-of-frame generation. Dropping it lets exactly one more start-of-frame go out, after which the block enters suspend.

Top module: `usbh_pipe_sched`

## Requirements
- R1: After reset the block is suspended (`suspended`=1), with `txn_valid`=0 and `sof_out`=0. While suspended, `sof_tick` produces no start-of-frame and no transaction is issued.
- R2: While suspended, `host_en`=1 clears `suspended`. From then on, each `sof_tick` pulse yields a one-cycle `sof_out` pulse in the following cycle.
- R3: Once `host_en` has dropped to 0, exactly one more start-of-frame is sent and the block is then suspended. Later ticks produce no start-of-frame and no transaction is issued.
- R4: The periodic phase visits pipes in the order 1, 2, 6, 7, 8, 9 and issues a transaction to every eligible interrupt or isochronous pipe in that order.
- R5: An interrupt or isochronous pipe is eligible only when `pipe_due` is 1. A bulk or control pipe is eligible whatever the value of `pipe_due`. Types are encoded in `pipe_type[2i+1:2i]` for pipe i as 0=control, 1=isochronous, 2=bulk, 3=interrupt.
- R6: After the periodic phase, pipe 0 is checked once. If `setup_req` is 1, a transaction of kind 0 (setup) is issued on pipe 0, whatever the pipe's direction or PID.
- R7: The bulk/control phase visits pipes 0, 1, 2, 3, 4, 5 in that order. A bulk, control or interrupt IN transaction (kind 1) needs PID=BUF and receive space. The matching OUT transaction (kind 2) needs PID=BUF and pending transmit data. `pipe_dir_in`=1 means IN.
- R8: An isochronous pipe with PID=BUF in a due frame is issued a transaction even when it has no buffer ready. The kind is 3 for IN and 4 for OUT.
- R9: `txn_valid`, `txn_pipe` and `txn_kind` hold steady until `txn_done` is seen. After completion the scan moves on to the next pipe in the order; the same pipe is never retried within that pass.
- R10: The bulk/control pass starts again from pipe 0 as long as its previous pass issued at least one transaction. A pass that issues nothing leaves the block idle until the next start-of-frame, even if a pipe becomes eligible in the meantime.
- R11: While `frame_ok` is 0, no new transaction is issued. The next start-of-frame restarts the sequence at the periodic phase.
- R12: A `sof_tick` that arrives while a transaction is outstanding is held back. The start-of-frame is sent after `txn_done`, and `sof_out` is never high in the same cycle as `txn_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host-mode enable |
| sof_tick | input | 1 | Frame timer pulse: a start-of-frame is due |
| frame_ok | input | 1 | Enough time left in the frame for another transaction |
| pipe_type | input | 20 | Two-bit type per pipe |
| pipe_dir_in | input | 10 | Per-pipe direction, 1=IN |
| pipe_pid_buf | input | 10 | Per-pipe PID is BUF |
| pipe_rx_room | input | 10 | Per-pipe receive area available |
| pipe_tx_data | input | 10 | Per-pipe transmit data pending |
| pipe_due | input | 10 | Per-pipe interval counter due this frame |
| setup_req | input | 1 | Setup request pending on pipe 0 |
| txn_done | input | 1 | Packet engine finished the current transaction |
| sof_out | output | 1 | One-cycle start-of-frame request |
| txn_valid | output | 1 | Transaction request outstanding |
| txn_pipe | output | 4 | Pipe number of the request |
| txn_kind | output | 3 | 0 setup, 1 IN, 2 OUT, 3 iso IN, 4 iso OUT |
| suspended | output | 1 | Block is in suspend |

## Verification
A corrupted phase or order index shows up at the ports on the very next transaction. The pipe number or kind leaves the expected sequence, or a pipe is skipped, and the bench compares the whole per-frame sequence entry by entry. A lost "found" flag, or a wrong deferred start-of-frame flag, appears within one pass of six cycles: the block either idles early, spins with nothing to do, or drops or doubles an `sof_out` pulse. A wrong suspend state is visible in the first cycle after the final start-of-frame, as a missing `suspended` flag or a stray request.

// File: rtl/usbh_sched_pkg.sv
package usbh_sched_pkg;

    localparam int NUM_PIPES = 10;
    localparam int PIPE_W    = $clog2(NUM_PIPES);
    localparam int ORDER_LEN = 6;
    localparam int IDX_W     = $clog2(ORDER_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ORDER_LEN - 1);

    typedef enum logic [1:0] {
        PT_CTRL = 2'd0,
        PT_ISO  = 2'd1,
        PT_BULK = 2'd2,
        PT_INTR = 2'd3
    } ptype_e;

    typedef enum logic [2:0] {
        TK_SETUP   = 3'd0,
        TK_IN      = 3'd1,
        TK_OUT     = 3'd2,
        TK_ISO_IN  = 3'd3,
        TK_ISO_OUT = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        ST_SUSP,
        ST_IDLE,
        ST_PER,
        ST_SETUP,
        ST_BULK,
        ST_WAIT
    } state_e;

    typedef struct packed {
        logic              ok;
        logic [PIPE_W-1:0] pipe;
        kind_e             kind;
    } cand_t;

    // pipe visited at a given step of the periodic pass
    function automatic logic [PIPE_W-1:0] per_order(input logic [IDX_W-1:0] idx);
        logic [PIPE_W-1:0] p;
        case (idx)
            3'd0:    p = PIPE_W'(1);
            3'd1:    p = PIPE_W'(2);
            3'd2:    p = PIPE_W'(6);
            3'd3:    p = PIPE_W'(7);
            3'd4:    p = PIPE_W'(8);
            default: p = PIPE_W'(9);
        endcase
        return p;
    endfunction

endpackage

// File: rtl/usbh_pipe_elig.sv
module usbh_pipe_elig
    import usbh_sched_pkg::*;
(
    input  logic [2*NUM_PIPES-1:0]   pipe_type,
    input  logic [NUM_PIPES-1:0]     pipe_dir_in,
    input  logic [NUM_PIPES-1:0]     pipe_pid_buf,
    input  logic [NUM_PIPES-1:0]     pipe_rx_room,
    input  logic [NUM_PIPES-1:0]     pipe_tx_data,
    input  logic [NUM_PIPES-1:0]     pipe_due,
    output logic [NUM_PIPES-1:0]     per_ok,
    output logic [NUM_PIPES-1:0]     blk_ok,
    output logic [NUM_PIPES-1:0][2:0] pipe_kind
);
    for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
        ptype_e ty;
        logic   buf_ready;
        assign ty        = ptype_e'(pipe_type[2*i +: 2]);
        assign buf_ready = pipe_dir_in[i] ? pipe_rx_room[i] : pipe_tx_data[i];

        always_comb begin
            per_ok[i] = 1'b0;
            blk_ok[i] = 1'b0;
            case (ty)
                PT_ISO:  per_ok[i] = pipe_pid_buf[i] & pipe_due[i];
                PT_INTR: per_ok[i] = pipe_pid_buf[i] & pipe_due[i] & buf_ready;
                default: blk_ok[i] = pipe_pid_buf[i] & buf_ready;
            endcase
            if (ty == PT_ISO)
                pipe_kind[i] = pipe_dir_in[i] ? TK_ISO_IN : TK_ISO_OUT;
            else
                pipe_kind[i] = pipe_dir_in[i] ? TK_IN : TK_OUT;
        end
    end
endmodule

// File: rtl/usbh_pipe_pick.sv
module usbh_pipe_pick
    import usbh_sched_pkg::*;
(
    input  state_e                    phase,
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM_PIPES-1:0]      per_ok,
    input  logic [NUM_PIPES-1:0]      blk_ok,
    input  logic [NUM_PIPES-1:0][2:0] pipe_kind,
    input  logic                      setup_req,
    output cand_t                     cand
);
    always_comb begin
        cand.ok   = 1'b0;
        cand.pipe = '0;
        cand.kind = TK_SETUP;
        case (phase)
            ST_PER: begin
                cand.pipe = per_order(idx);
                cand.ok   = per_ok[cand.pipe];
                cand.kind = kind_e'(pipe_kind[cand.pipe]);
            end
            ST_SETUP: begin
                cand.ok   = setup_req;
            end
            ST_BULK: begin
                cand.pipe = PIPE_W'(idx);
                cand.ok   = blk_ok[cand.pipe];
                cand.kind = kind_e'(pipe_kind[cand.pipe]);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usbh_pipe_sched.sv
module usbh_pipe_sched
    import usbh_sched_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_en,
    input  logic                   sof_tick,
    input  logic                   frame_ok,
    input  logic [2*NUM_PIPES-1:0] pipe_type,
    input  logic [NUM_PIPES-1:0]   pipe_dir_in,
    input  logic [NUM_PIPES-1:0]   pipe_pid_buf,
    input  logic [NUM_PIPES-1:0]   pipe_rx_room,
    input  logic [NUM_PIPES-1:0]   pipe_tx_data,
    input  logic [NUM_PIPES-1:0]   pipe_due,
    input  logic                   setup_req,
    input  logic                   txn_done,
    output logic                   sof_out,
    output logic                   txn_valid,
    output logic [PIPE_W-1:0]      txn_pipe,
    output logic [2:0]             txn_kind,
    output logic                   suspended
);
    state_e                    state, ret, ph, adv_state;
    logic [IDX_W-1:0]          idx, adv_idx;
    logic                      found, adv_found, sof_pend, sof_evt;
    logic [NUM_PIPES-1:0]      per_ok, blk_ok;
    logic [NUM_PIPES-1:0][2:0] pipe_kind;
    cand_t                     cand;

    usbh_pipe_elig u_elig (
        .pipe_type    (pipe_type),
        .pipe_dir_in  (pipe_dir_in),
        .pipe_pid_buf (pipe_pid_buf),
        .pipe_rx_room (pipe_rx_room),
        .pipe_tx_data (pipe_tx_data),
        .pipe_due     (pipe_due),
        .per_ok       (per_ok),
        .blk_ok       (blk_ok),
        .pipe_kind    (pipe_kind)
    );

    usbh_pipe_pick u_pick (
        .phase     (state),
        .idx       (idx),
        .per_ok    (per_ok),
        .blk_ok    (blk_ok),
        .pipe_kind (pipe_kind),
        .setup_req (setup_req),
        .cand      (cand)
    );

    // phase being scanned, including while a request is outstanding
    assign ph = (state == ST_WAIT) ? ret : state;

    // next scan position after the current pipe is finished or skipped
    always_comb begin
        adv_state = ph;
        adv_idx   = idx + 1'b1;
        adv_found = found;
        case (ph)
            ST_PER: if (idx == IDX_LAST) begin
                adv_state = ST_SETUP;
                adv_idx   = '0;
            end
            ST_SETUP: begin
                adv_state = ST_BULK;
                adv_idx   = '0;
                adv_found = 1'b0;
            end
            ST_BULK: if (idx == IDX_LAST) begin
                adv_state = found ? ST_BULK : ST_IDLE;
                adv_idx   = '0;
                adv_found = 1'b0;
            end
            default: begin
                adv_state = ST_IDLE;
                adv_idx   = '0;
            end
        endcase
    end

    assign sof_evt   = (sof_tick | sof_pend) && state != ST_SUSP && state != ST_WAIT;
    assign suspended = (state == ST_SUSP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_SUSP;
            ret       <= ST_IDLE;
            idx       <= '0;
            found     <= 1'b0;
            sof_pend  <= 1'b0;
            sof_out   <= 1'b0;
            txn_valid <= 1'b0;
            txn_pipe  <= '0;
            txn_kind  <= TK_SETUP;
        end else begin
            sof_out <= 1'b0;
            if (state == ST_SUSP) begin
                sof_pend <= 1'b0;
                if (host_en) state <= ST_IDLE;
            end else if (sof_evt) begin
                sof_out  <= 1'b1;
                sof_pend <= 1'b0;
                state    <= host_en ? ST_PER : ST_SUSP;
                idx      <= '0;
                found    <= 1'b0;
            end else begin
                if (sof_tick) sof_pend <= 1'b1;
                case (state)
                    ST_PER, ST_SETUP, ST_BULK: begin
                        if (!frame_ok) begin
                            state <= ST_IDLE;
                        end else if (cand.ok) begin
                            txn_valid <= 1'b1;
                            txn_pipe  <= cand.pipe;
                            txn_kind  <= cand.kind;
                            ret       <= state;
                            state     <= ST_WAIT;
                            if (state == ST_BULK) found <= 1'b1;
                        end else begin
                            state <= adv_state;
                            idx   <= adv_idx;
                            found <= adv_found;
                        end
                    end
                    ST_WAIT: if (txn_done) begin
                        txn_valid <= 1'b0;
                        state     <= adv_state;
                        idx       <= adv_idx;
                        found     <= adv_found;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/usbh_sched_chk.sv
module usbh_sched_chk
    import usbh_sched_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_en,
    input logic              txn_done,
    input logic              sof_out,
    input logic              txn_valid,
    input logic [PIPE_W-1:0] txn_pipe,
    input logic [2:0]        txn_kind,
    input logic              suspended
);
    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_done |=> txn_valid && $stable(txn_pipe) && $stable(txn_kind));

    // R1
    quiet_susp_chk: assert property (@(posedge clk) disable iff (rst)
        suspended && $past(suspended) |-> !txn_valid && !sof_out);

    // R2
    wake_en_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(suspended) |-> $past(host_en));

    // R6
    setup_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && txn_kind == 3'd0 |-> txn_pipe == '0);

    // R8
    iso_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && (txn_kind == 3'd3 || txn_kind == 3'd4) |->
        (txn_pipe == 4'd1 || txn_pipe == 4'd2 || txn_pipe == 4'd6 ||
         txn_pipe == 4'd7 || txn_pipe == 4'd8 || txn_pipe == 4'd9));

    // R12
    sof_apart_chk: assert property (@(posedge clk) disable iff (rst)
        sof_out |-> !txn_valid);
endmodule

bind usbh_pipe_sched usbh_sched_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_en   (host_en),
    .txn_done  (txn_done),
    .sof_out   (sof_out),
    .txn_valid (txn_valid),
    .txn_pipe  (txn_pipe),
    .txn_kind  (txn_kind),
    .suspended (suspended)
);

// File: tb/sim_usbh_pipe_sched.sv
module sim_usbh_pipe_sched;
    logic        clk = 0;
    logic        rst = 1;
    logic        host_en = 0, sof_tick = 0, frame_ok = 0, setup_req = 0, txn_done = 0;
    logic [19:0] pipe_type = '0;
    logic [9:0]  pipe_dir_in = '0, pipe_pid_buf = '0, pipe_rx_room = '0;
    logic [9:0]  pipe_tx_data = '0, pipe_due = '0;
    logic        sof_out, txn_valid, suspended;
    logic [3:0]  txn_pipe;
    logic [2:0]  txn_kind;

    int total = 0, bad = 0;
    int sof_cnt = 0, log_n = 0;
    logic auto_done = 1, man_done = 0;
    logic [3:0] log_pipe [64];
    logic [2:0] log_kind [64];

    always #2 clk = ~clk;

    usbh_pipe_sched u0 (.*);

    // device side: acknowledge, log requests, count start-of-frame pulses
    always @(negedge clk) begin
        if (sof_out) sof_cnt <= sof_cnt + 1;
        if (auto_done) begin
            if (txn_valid && !txn_done && log_n < 64) begin
                log_pipe[log_n] <= txn_pipe;
                log_kind[log_n] <= txn_kind;
                log_n <= log_n + 1;
            end
            txn_done <= txn_valid && !txn_done;
        end else begin
            txn_done <= man_done;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) sof_tick = 1;
        @(negedge clk) sof_tick = 0;
    endtask

    task automatic clear_log();
        @(negedge clk);
        log_n = 0;
    endtask

    task automatic set_pipe(input int p, input int ty, input bit din, input bit pid,
                            input bit rx, input bit tx, input bit due);
        pipe_type[2*p +: 2] = 2'(ty);
        pipe_dir_in[p] = din; pipe_pid_buf[p] = pid;
        pipe_rx_room[p] = rx; pipe_tx_data[p] = tx; pipe_due[p] = due;
    endtask

    task automatic t_reset();
        cyc(1);
        check("R1 suspended", suspended, 1);
        check("R1 txn_valid", txn_valid, 0);
        check("R1 sof_out", sof_out, 0);
        tick(); cyc(3);
        check("R1 sof ignored", sof_cnt, 0);
    endtask

    task automatic t_enable();
        host_en = 1; cyc(2);
        check("R2 leaves suspend", suspended, 0);
        tick(); cyc(1);
        check("R2 one sof", sof_cnt, 1);
    endtask

    task automatic t_frame();
        int exp_p [9] = '{1, 2, 8, 9, 0, 3, 5, 3, 5};
        int exp_k [9] = '{1, 4, 2, 3, 0, 2, 1, 2, 1};
        set_pipe(0, 0, 0, 0, 0, 1, 0);   // control, PID not BUF
        set_pipe(1, 3, 1, 1, 1, 0, 1);   // interrupt IN due
        set_pipe(2, 1, 0, 1, 0, 0, 1);   // iso OUT due, no data
        set_pipe(6, 3, 1, 1, 0, 0, 1);   // interrupt IN, no room
        set_pipe(7, 1, 1, 1, 1, 0, 0);   // iso IN, not due
        set_pipe(8, 3, 0, 1, 0, 1, 1);   // interrupt OUT due
        set_pipe(9, 1, 1, 1, 0, 0, 1);   // iso IN due, no room
        set_pipe(3, 2, 0, 1, 0, 1, 0);   // bulk OUT
        set_pipe(4, 2, 1, 0, 1, 0, 1);   // bulk IN, PID not BUF
        set_pipe(5, 2, 1, 1, 1, 0, 0);   // bulk IN, not due
        setup_req = 1; frame_ok = 1;
        clear_log(); tick(); cyc(60);
        frame_ok = 0; cyc(5);
        check("R10 entries logged", int'(log_n >= 9), 1);
        for (int i = 0; i < 9; i++) begin
            check($sformatf("R4 R6 R7 R10 pipe at %0d", i), log_pipe[i], exp_p[i]);
            check($sformatf("R5 R8 kind at %0d", i), log_kind[i], exp_k[i]);
        end
        clear_log(); cyc(20);
        check("R11 nothing after frame end", log_n, 0);
        frame_ok = 1; tick(); cyc(4);
        check("R11 restart periodic", log_pipe[0], 1);
        frame_ok = 0; setup_req = 0; cyc(10);
    endtask

    task automatic t_idle();
        pipe_pid_buf = '0; frame_ok = 1;
        clear_log(); tick(); cyc(30);
        check("R10 empty pass", log_n, 0);
        pipe_pid_buf[3] = 1; cyc(20);
        check("R10 idle till sof", log_n, 0);
        tick(); cyc(14);
        check("R10 served after sof", log_pipe[0], 3);
        frame_ok = 0; cyc(10);
    endtask

    task automatic t_hold();
        int s0;
        pipe_pid_buf = '0; pipe_pid_buf[3] = 1; frame_ok = 1;
        auto_done = 0; cyc(2);
        tick();
        for (int i = 0; i < 20 && !txn_valid; i++) cyc(1);
        check("R9 request raised", txn_valid, 1);
        check("R7 pipe", txn_pipe, 3);
        cyc(8);
        check("R9 held", txn_valid, 1);
        check("R9 pipe stable", txn_pipe, 3);
        s0 = sof_cnt;
        tick(); cyc(4);
        check("R12 sof deferred", sof_cnt, s0);
        @(negedge clk) man_done = 1;
        @(negedge clk) man_done = 0;
        cyc(4);
        check("R12 sof after done", sof_cnt, s0 + 1);
        frame_ok = 0; cyc(6);
        auto_done = 1; cyc(4);
    endtask

    task automatic t_stop();
        int s0;
        frame_ok = 0; host_en = 0; cyc(4);
        check("R3 still running", suspended, 0);
        s0 = sof_cnt;
        tick(); cyc(2);
        check("R3 last sof", sof_cnt, s0 + 1);
        check("R3 suspended", suspended, 1);
        frame_ok = 1; pipe_pid_buf = '1; setup_req = 1;
        clear_log(); tick(); cyc(20);
        check("R3 no more sof", sof_cnt, s0 + 1);
        check("R3 no txn", log_n, 0);
    endtask

    initial begin
        int wd = 0;
        fork
            begin
                cyc(3); rst = 0;
                t_reset(); t_enable(); t_frame(); t_idle(); t_hold(); t_stop();
            end
            begin
                while (wd < 100000) begin cyc(1); wd++; end
            end
        join_any
        if (wd >= 100000) check("watchdog", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule